// File: doc/BRIEF.md
# Color-Channel Select and Reset-Level Clamp Controller

This block is the digital control for a color digitiser that has a single analog input and works line by line. It tells the analog front end which color's offset and gain register set (red, green or blue) to apply to the one input. The color is chosen in one of two ways. In the first, a two-bit select field in a configuration register gives the color directly. In the second, an auto-cycle sequencer steps through red, green and blue, then back to red, on each pulse of the reset-sample strobe.

The block also drives the enable for the reset-level clamp switch. It takes that enable from the two sampling strobes and from configuration bits, and the way the clamp is sourced changes when auto-cycling is on. Software writes one 7-bit configuration word through a simple write port. If the word holds a reserved select code, or turns on correlated double sampling while auto-cycling, the block raises a sticky error flag.

Top module: `colorClampCtrl`

Configuration word: bit 0 `lineMode`, bit 1 `autoCycle`, bits 3:2 `selCode`, bit 4 `clampAnd`, bit 5 `clampEn`, bit 6 `cdsEn`. Color select output: bit 0 red, bit 1 green, bit 2 blue.

## Requirements
- R1: After reset every configuration bit is 0, `cfgErr` is 0, `clampClose` is 0 and `colorSel` is 3'b111.
- R2: While `lineMode` (bit 0) is 0, `colorSel` is 3'b111, meaning each channel uses its own set. `autoCycle`, `selCode` and strobe pulses have no effect on it.
- R3: With `lineMode`=1 and `autoCycle` (bit 1)=0, `selCode` (bits 3:2) picks the color: 00 drives `colorSel`=3'b001 (red), 01 drives 3'b010 (green), 10 drives 3'b100 (blue). The change is visible in the cycle after the write.
- R4: A write whose `selCode` is the reserved value 11 sets `cfgErr` and keeps the previous select code. The other fields of that write still take effect.
- R5: With `lineMode`=1 and `autoCycle`=1, each rising edge of `resetStrobe` advances `colorSel` one step in the order red, green, blue, red. The step is visible on the third rising clock edge after the strobe goes high. A strobe held high for many cycles advances it only once.
- R6: Any configuration write returns the auto-cycle sequence to red.
- R7: While auto-cycling, `selCode` has no effect on `colorSel`.
- R8: While `clampEn` (bit 5) is 0, `clampClose` is 0.
- R9: With `clampEn`=1, `clampAnd` (bit 4)=0 and no auto-cycling, `clampClose` follows `resetStrobe`, two clock edges late.
- R10: With `clampEn`=1 and `clampAnd`=1, `clampClose` is 1 only when both strobes, each delayed by two clock edges, are high.
- R11: While auto-cycling with `clampAnd`=0, `clampClose` stays 0.
- R12: A write with `cdsEn` (bit 6)=1 together with `lineMode`=1 and `autoCycle`=1 sets `cfgErr`. Once set, `cfgErr` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Configuration write strobe |
| wrData | input | 7 | Configuration word |
| resetStrobe | input | 1 | Reset-sample strobe, asynchronous |
| videoStrobe | input | 1 | Video-sample strobe, asynchronous |
| colorSel | output | 3 | Color register set select (one-hot in line mode) |
| clampClose | output | 1 | Reset-level clamp switch close |
| cfgErr | output | 1 | Sticky configuration error |

## Verification
The assertions check four rules on every cycle. `colorSel` is one-hot in line mode and all ones outside it. The clamp stays open whenever it is disabled, and whenever auto-cycling runs with `clampAnd` clear. In auto mode the select only ever rotates by one position, and the error flag never falls. What only the bench scenarios can show is timing and sequence. That covers the exact three-edge delay from strobe to step, a long pulse giving a single step, a write returning the sequence to red, a reserved code keeping the previous color, and the two-edge delay of the clamp with each clamp-source choice.

// File: rtl/colorClampPkg.sv
package colorClampPkg;

  typedef struct packed {
    logic       cdsEn;
    logic       clampEn;
    logic       clampAnd;
    logic [1:0] selCode;
    logic       autoCycle;
    logic       lineMode;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
  localparam logic [1:0] SEL_RESERVED = 2'b11;

  typedef struct packed {
    logic seqClear;
    logic stepAdv;
    logic rsLvl;
    logic vsLvl;
  } strobe_t;

endpackage

// File: rtl/colorCtrl.sv
module colorCtrl
  import colorClampPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CFG_W-1:0] wrData,
  input  logic             resetStrobe,
  input  logic             videoStrobe,
  output cfg_t             cfgQ,
  output strobe_t          strb,
  output logic             cfgErr
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] rsPipe;
  logic [SYNC_STAGES-1:0] vsPipe;
  logic                   rsPrev;
  cfg_t                   cfgIn;
  cfg_t                   cfgNext;
  logic                   badWrite;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rsPipe <= '0;
          vsPipe <= '0;
        end else begin
          rsPipe <= {rsPipe[SYNC_STAGES-2:0], resetStrobe};
          vsPipe <= {vsPipe[SYNC_STAGES-2:0], videoStrobe};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rsPipe <= '0;
          vsPipe <= '0;
        end else begin
          rsPipe <= resetStrobe;
          vsPipe <= videoStrobe;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rsPrev <= 1'b0;
    else       rsPrev <= rsPipe[LAST];
  end

  always_comb begin
    cfgIn   = cfg_t'(wrData);
    cfgNext = cfgIn;
    if (cfgIn.selCode == SEL_RESERVED) cfgNext.selCode = cfgQ.selCode;
    badWrite = (cfgIn.selCode == SEL_RESERVED) ||
               (cfgIn.cdsEn && cfgIn.autoCycle && cfgIn.lineMode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ   <= '0;
      cfgErr <= 1'b0;
    end else if (wrEn) begin
      cfgQ   <= cfgNext;
      cfgErr <= cfgErr | badWrite;
    end
  end

  always_comb begin
    strb.seqClear = wrEn;
    strb.stepAdv  = rsPipe[LAST] & ~rsPrev;
    strb.rsLvl    = rsPipe[LAST];
    strb.vsLvl    = vsPipe[LAST];
  end

endmodule

// File: rtl/colorDatapath.sv
module colorDatapath
  import colorClampPkg::*;
#(
  parameter int NUM_COLORS = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cfg_t                  cfgQ,
  input  strobe_t               strb,
  output logic                  autoOn,
  output logic [NUM_COLORS-1:0] colorSel,
  output logic                  clampClose
);

  localparam int IDX_W = (NUM_COLORS > 2) ? $clog2(NUM_COLORS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_COLORS - 1);

  logic [IDX_W-1:0] step;
  logic [IDX_W-1:0] colorIdx;

  assign autoOn = cfgQ.lineMode & cfgQ.autoCycle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step <= '0;
    end else if (strb.seqClear) begin
      step <= '0;
    end else if (strb.stepAdv && autoOn) begin
      step <= (step == LAST_IDX) ? '0 : step + 1'b1;
    end
  end

  assign colorIdx = autoOn ? step : IDX_W'(cfgQ.selCode);

  generate
    for (genvar g = 0; g < NUM_COLORS; g++) begin : g_dec
      assign colorSel[g] = ~cfgQ.lineMode | (colorIdx == IDX_W'(g));
    end
  endgenerate

  always_comb begin
    if (!cfgQ.clampEn)      clampClose = 1'b0;
    else if (cfgQ.clampAnd) clampClose = strb.rsLvl & strb.vsLvl;
    else                    clampClose = strb.rsLvl & ~autoOn;
  end

endmodule

// File: rtl/colorClampCtrl.sv
module colorClampCtrl
  import colorClampPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_COLORS  = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [CFG_W-1:0]      wrData,
  input  logic                  resetStrobe,
  input  logic                  videoStrobe,
  output logic [NUM_COLORS-1:0] colorSel,
  output logic                  clampClose,
  output logic                  cfgErr
);

  cfg_t    cfgQ;
  strobe_t strb;
  logic    autoOn;

  colorCtrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .resetStrobe(resetStrobe), .videoStrobe(videoStrobe),
    .cfgQ(cfgQ), .strb(strb), .cfgErr(cfgErr)
  );

  colorDatapath #(.NUM_COLORS(NUM_COLORS)) i_dp (
    .clk(clk), .rstN(rstN), .cfgQ(cfgQ), .strb(strb),
    .autoOn(autoOn), .colorSel(colorSel), .clampClose(clampClose)
  );

endmodule

// File: rtl/colorClampChk.sv
module colorClampChk #(
  parameter int NUM_COLORS = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [6:0]            wrData,
  input logic [NUM_COLORS-1:0] colorSel,
  input logic                  clampClose,
  input logic                  cfgErr,
  input logic                  lineMode,
  input logic                  autoOn,
  input logic                  clampEn,
  input logic                  clampAnd
);

  p_onehot_line_r3: assert property (@(posedge clk) disable iff (!rstN)
    lineMode |-> ($countones(colorSel) == 1));

  p_all_on_r2: assert property (@(posedge clk) disable iff (!rstN)
    !lineMode |-> (&colorSel));

  p_clamp_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    !clampEn |-> !clampClose);

  p_auto_clamp_open_r11: assert property (@(posedge clk) disable iff (!rstN)
    (autoOn && !clampAnd) |-> !clampClose);

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);

  p_rotate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (autoOn && $past(autoOn) && !$past(wrEn) && (colorSel != $past(colorSel)))
    |-> (colorSel == {$past(colorSel[NUM_COLORS-2:0]), $past(colorSel[NUM_COLORS-1])}));

  p_reserved_keeps_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrEn) && ($past(wrData[3:2]) == 2'b11) && lineMode && !autoOn &&
     $past(lineMode) && !$past(autoOn)) |-> $stable(colorSel));

endmodule

bind colorClampCtrl colorClampChk #(.NUM_COLORS(NUM_COLORS)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
  .colorSel(colorSel), .clampClose(clampClose), .cfgErr(cfgErr),
  .lineMode(cfgQ.lineMode), .autoOn(autoOn),
  .clampEn(cfgQ.clampEn), .clampAnd(cfgQ.clampAnd)
);

// File: tb/test_colorClampCtrl.sv
module test_colorClampCtrl;

  localparam logic [6:0] LINE = 7'h01, AUTO = 7'h02, AND_ = 7'h10,
                         CEN = 7'h20, CDS = 7'h40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [6:0] wrData = '0;
  logic       resetStrobe = 1'b0;
  logic       videoStrobe = 1'b0;
  logic [2:0] colorSel;
  logic       clampClose;
  logic       cfgErr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  string curReq = "R1";

  // reference model state
  int mRs1, mRs2, mRsPrev, mVs1, mVs2, mSel, mStep;
  logic [6:0] mCfg;
  bit mErr;

  always #5 clk = ~clk;

  colorClampCtrl i_colorClampCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .resetStrobe(resetStrobe), .videoStrobe(videoStrobe),
    .colorSel(colorSel), .clampClose(clampClose), .cfgErr(cfgErr)
  );

  function automatic logic [6:0] sel(input int s);
    return 7'(s << 2);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRs1 = 0; mRs2 = 0; mRsPrev = 0; mVs1 = 0; mVs2 = 0;
      mSel = 0; mStep = 0; mCfg = '0; mErr = 0;
    end else begin
      bit rise, autoNow;
      int s;
      rise    = (mRs2 != 0) && (mRsPrev == 0);
      autoNow = mCfg[0] && mCfg[1];
      if (wrEn) begin
        s = int'(wrData[3:2]);
        if (s == 3 || (wrData[6] && wrData[1] && wrData[0])) mErr = 1;
        if (s != 3) mSel = s;
        mCfg = wrData;
        mStep = 0;
      end else if (rise && autoNow) begin
        mStep = (mStep + 1) % 3;
      end
      mRsPrev = mRs2; mRs2 = mRs1; mRs1 = int'(resetStrobe);
      mVs2 = mVs1; mVs1 = int'(videoStrobe);
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      bit line, autoNow, expClamp;
      int idx;
      logic [2:0] expSel;
      line    = mCfg[0];
      autoNow = line && mCfg[1];
      idx     = autoNow ? mStep : mSel;
      expSel  = line ? 3'(1 << idx) : 3'b111;
      expClamp = mCfg[5] && (mCfg[4] ? (mRs2 != 0 && mVs2 != 0)
                                     : (mRs2 != 0 && !autoNow));
      checks += 3;
      if (colorSel !== expSel) begin
        errors++;
        $display("FAIL %s colorSel actual %b expected %b", curReq, colorSel, expSel);
      end
      if (clampClose !== expClamp) begin
        errors++;
        $display("FAIL %s clampClose actual %b expected %b", curReq, clampClose, expClamp);
      end
      if (cfgErr !== mErr) begin
        errors++;
        $display("FAIL %s cfgErr actual %b expected %b", curReq, cfgErr, mErr);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired in %s", curReq);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCfg(input logic [6:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    tick(1);
  endtask

  task automatic pulseRs(input int len);
    resetStrobe = 1'b1;
    tick(len);
    resetStrobe = 1'b0;
    tick(4);
  endtask

  task automatic pulseBoth(input bit rs, input bit vs, input int len);
    resetStrobe = rs; videoStrobe = vs;
    tick(len);
    resetStrobe = 1'b0; videoStrobe = 1'b0;
    tick(4);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    curReq = "R1"; tick(3);

    curReq = "R2";
    wrCfg(AUTO | sel(1) | CEN);
    pulseRs(1); pulseRs(2);

    curReq = "R3";
    for (int s = 0; s < 3; s++) begin
      wrCfg(LINE | sel(s));
      tick(2);
    end

    curReq = "R4";
    wrCfg(LINE | sel(1));
    wrCfg(LINE | sel(3) | CEN);
    tick(2);
    pulseRs(2);

    rstN = 1'b0; tick(2); rstN = 1'b1;

    curReq = "R5";
    wrCfg(LINE | AUTO);
    for (int k = 0; k < 4; k++) pulseRs(1);
    pulseRs(12);
    pulseRs(3);

    curReq = "R6";
    pulseRs(1);
    wrCfg(LINE | AUTO | CEN | AND_);
    tick(2);

    curReq = "R7";
    wrCfg(LINE | AUTO | sel(2));
    pulseRs(1);
    wrCfg(LINE | AUTO | sel(1));
    pulseRs(1);

    curReq = "R8";
    wrCfg(LINE);
    pulseBoth(1, 1, 3);

    curReq = "R9";
    wrCfg(LINE | CEN | sel(2));
    pulseRs(3);
    pulseBoth(0, 1, 2);

    curReq = "R10";
    wrCfg(LINE | CEN | AND_);
    pulseBoth(1, 0, 3);
    pulseBoth(0, 1, 3);
    pulseBoth(1, 1, 3);

    curReq = "R11";
    wrCfg(LINE | AUTO | CEN);
    pulseRs(3); pulseRs(2);

    curReq = "R12";
    wrCfg(LINE | AUTO | CDS);
    tick(2);
    wrCfg(LINE);
    tick(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule